// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block turns synchronised write cycles from a parallel flash bus into decoded command requests. Each write carries a word address, a byte-lane bit used only in byte-wide mode, a data word and a byte-mode flag. The block recognises the multi-cycle unlock sequences that guard every state-changing command. When a sequence completes, it raises a single-cycle strobe with a one-hot command code. For program requests it also presents the target address and data.

The block tracks the interface mode: array read, identifier, query table, unlock bypass, and busy with a program or erase. It also holds an erase-suspended flag. Commands that the current mode does not allow are masked. A pulse from the program/erase controller tells the decoder that the running operation has finished. The controller, the memory array and the pin timing sit outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After the asynchronous reset, or after a one-cycle `sync_clr`, the decoder is in array mode with no partial sequence, every mode flag low, `erase_susp` low and `cmd_vld` low.
- R2: The unlock prefix is data AA at key address 1 followed by data 55 at key address 2. In word mode the key addresses are 555 and 2AA, compared against `wr_addr[10:0]`. In byte mode they are AAA and 555, compared against `{wr_addr[10:0], wr_lsb}`. The byte mode is taken from each write. A prefix followed by 90 at key address 1 strobes the identifier command (code bit 1) and enters identifier mode.
- R3: A prefix, then A0 at key address 1, then any fourth write strobes program (code bit 2). `cmd_addr` is `{wr_addr, wr_lsb}` in byte mode and `{wr_addr, 0}` in word mode. `cmd_data` is the data of the fourth write. The decoder then stays busy until `pe_done`.
- R4: Matching uses only the low 11 address bits, plus `wr_lsb` in byte mode, and data bits 7:0. Upper address bits and data bits 15:8 do not change the outcome.
- R5: A write that breaks a sequence discards the partial sequence without a strobe and leaves the decoder in array mode.
- R6: F0 written to any address strobes read/reset (code bit 0). A prefix followed by F0 also strobes read/reset. Writing 98 to the query address strobes query entry (code bit 8) and sets `mode_query`. The query address is 55 in word mode and AA in byte mode.
- R7: Read/reset in query mode returns to the mode that preceded it. From identifier mode, two resets are therefore needed to reach array mode.
- R8: In identifier mode every write other than F0, or 98 at the query address, is ignored and the mode is kept.
- R9: A prefix followed by 20 at key address 1 strobes bypass entry (code bit 9). In bypass mode, A0 followed by any write strobes bypass program (code bit 3), and the decoder returns to bypass mode after `pe_done`. F0 strobes read/reset but keeps bypass mode. 90 followed by 00 strobes bypass exit (code bit 10) and returns to array mode.
- R10: A prefix, 80 at key address 1, a second prefix, then 10 at key address 1 strobes chip erase (code bit 4). If the last write is 30 at any address, it strobes block erase (code bit 5). Both set `busy`.
- R11: While busy, writes produce no strobe. The one exception is B0 during a block erase, which strobes suspend (code bit 6), leaves busy and sets `erase_susp`.
- R12: 30 strobes resume (code bit 7), sets busy and clears `erase_susp` only while suspended and in array mode. In any other mode it produces nothing.
- R13: `cmd_vld` is high for exactly one cycle per decoded command, with exactly one bit of `cmd_code` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous clear of sequence and mode state |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_lsb | input | 1 | Byte-lane address bit, used in byte mode |
| wr_data | input | DATA_W | Write data |
| byte_mode | input | 1 | 1 = byte-wide bus for this write |
| pe_done | input | 1 | Controller pulse: running operation finished |
| cmd_vld | output | 1 | Decoded command strobe |
| cmd_code | output | 11 | One-hot command code |
| cmd_addr | output | ADDR_W+1 | Byte-granular address of the final write |
| cmd_data | output | DATA_W | Data of the final write |
| mode_ident | output | 1 | Identifier mode |
| mode_query | output | 1 | Query-table mode |
| mode_bypass | output | 1 | Unlock-bypass mode |
| busy | output | 1 | Program or erase in progress |
| erase_susp | output | 1 | Block erase suspended |

## Verification
Every result is due one cycle after its stimulus. A write sampled on a rising edge updates `cmd_vld`, `cmd_code` and the mode flags on that same edge, and they are read at the next falling edge. Read-only writes and `pe_done` behave the same way. The driver pushes one expected item per write. The monitor pops that item at the falling edge after the edge that sampled the write, and it requires `cmd_vld` low on every cycle without a write. Mode flags are compared at that same falling edge, before the next write is driven.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int CMD_N   = 11;
  localparam int IDX_W   = 4;
  localparam int KEY_W   = 12;

  // bit position of each command in the one-hot code
  typedef enum logic [IDX_W-1:0] {
    C_RESET   = 4'd0,
    C_IDENT   = 4'd1,
    C_PROG    = 4'd2,
    C_BPROG   = 4'd3,
    C_CHIP    = 4'd4,
    C_BLK     = 4'd5,
    C_SUSP    = 4'd6,
    C_RESUME  = 4'd7,
    C_QUERY   = 4'd8,
    C_BYP_IN  = 4'd9,
    C_BYP_OUT = 4'd10
  } cmd_idx_e;

  typedef enum logic [3:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PDATA,
    S_ERS1, S_ERS2, S_ERS3,
    S_IDENT, S_QUERY,
    S_BYP, S_BPDATA, S_BEXIT,
    S_BUSY, S_BUSY_BE
  } seq_st_e;

  typedef struct packed {
    logic k1;
    logic k2;
    logic qry;
  } key_hit_t;

  localparam logic [7:0] OP_RESET  = 8'hF0;
  localparam logic [7:0] OP_K1     = 8'hAA;
  localparam logic [7:0] OP_K2     = 8'h55;
  localparam logic [7:0] OP_IDENT  = 8'h90;
  localparam logic [7:0] OP_PROG   = 8'hA0;
  localparam logic [7:0] OP_BYP    = 8'h20;
  localparam logic [7:0] OP_ERASE  = 8'h80;
  localparam logic [7:0] OP_CHIP   = 8'h10;
  localparam logic [7:0] OP_BLK    = 8'h30;
  localparam logic [7:0] OP_SUSP   = 8'hB0;
  localparam logic [7:0] OP_QUERY  = 8'h98;
  localparam logic [7:0] OP_BEXIT  = 8'h00;

  localparam logic [KEY_W-1:0] W_K1 = 12'h555;
  localparam logic [KEY_W-1:0] W_K2 = 12'h2AA;
  localparam logic [KEY_W-1:0] W_QA = 12'h055;
  localparam logic [KEY_W-1:0] B_K1 = 12'hAAA;
  localparam logic [KEY_W-1:0] B_K2 = 12'h555;
  localparam logic [KEY_W-1:0] B_QA = 12'h0AA;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
(
  input  logic [10:0] addr_lo,
  input  logic        lsb,
  input  logic        byte_mode,
  output key_hit_t    hit
);

  logic [KEY_W-1:0] cmp;
  logic [KEY_W-1:0] exp_k1, exp_k2, exp_qa;

  // byte mode shifts the word address up and appends the lane bit
  always_comb begin
    if (byte_mode) begin
      cmp    = {addr_lo, lsb};
      exp_k1 = B_K1;
      exp_k2 = B_K2;
      exp_qa = B_QA;
    end else begin
      cmp    = {1'b0, addr_lo};
      exp_k1 = W_K1;
      exp_k2 = W_K2;
      exp_qa = W_QA;
    end
    hit.k1  = (cmp == exp_k1);
    hit.k2  = (cmp == exp_k2);
    hit.qry = (cmp == exp_qa);
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_clr,
  input  logic             wr_stb,
  input  key_hit_t         hit,
  input  logic [7:0]       op,
  input  logic             pe_done,
  output logic             emit,
  output logic [IDX_W-1:0] emit_idx,
  output logic             mode_ident,
  output logic             mode_query,
  output logic             mode_bypass,
  output logic             busy,
  output logic             erase_susp
);

  seq_st_e  st_q, st_n;
  logic     susp_q, susp_n;
  logic     qret_q, qret_n;   // query entered from identifier mode
  logic     bret_q, bret_n;   // program issued from bypass mode
  cmd_idx_e idx_n;
  logic     adv;

  assign adv = wr_stb | pe_done;

  always_comb begin
    st_n   = st_q;
    susp_n = susp_q;
    qret_n = qret_q;
    bret_n = bret_q;
    emit   = 1'b0;
    idx_n  = C_RESET;
    if (wr_stb) begin
      unique case (st_q)
        S_IDLE: begin
          if (op == OP_RESET) begin
            emit = 1'b1;
          end else if (op == OP_QUERY && hit.qry) begin
            emit = 1'b1; idx_n = C_QUERY; st_n = S_QUERY; qret_n = 1'b0;
          end else if (op == OP_BLK && susp_q) begin
            emit = 1'b1; idx_n = C_RESUME; st_n = S_BUSY_BE; susp_n = 1'b0;
          end else if (op == OP_K1 && hit.k1) begin
            st_n = S_UNL1;
          end
        end
        S_UNL1: st_n = (op == OP_K2 && hit.k2) ? S_UNL2 : S_IDLE;
        S_UNL2: begin
          st_n = S_IDLE;
          if (op == OP_RESET) begin
            emit = 1'b1;
          end else if (hit.k1) begin
            if (op == OP_IDENT) begin
              emit = 1'b1; idx_n = C_IDENT; st_n = S_IDENT;
            end else if (op == OP_PROG) begin
              st_n = S_PDATA;
            end else if (op == OP_BYP) begin
              emit = 1'b1; idx_n = C_BYP_IN; st_n = S_BYP;
            end else if (op == OP_ERASE && !susp_q) begin
              st_n = S_ERS1;
            end
          end
        end
        S_PDATA: begin
          emit = 1'b1; idx_n = C_PROG; st_n = S_BUSY; bret_n = 1'b0;
        end
        S_ERS1: st_n = (op == OP_K1 && hit.k1) ? S_ERS2 : S_IDLE;
        S_ERS2: st_n = (op == OP_K2 && hit.k2) ? S_ERS3 : S_IDLE;
        S_ERS3: begin
          st_n = S_IDLE;
          if (op == OP_CHIP && hit.k1) begin
            emit = 1'b1; idx_n = C_CHIP; st_n = S_BUSY; bret_n = 1'b0;
          end else if (op == OP_BLK) begin
            emit = 1'b1; idx_n = C_BLK; st_n = S_BUSY_BE;
          end
        end
        S_IDENT: begin
          if (op == OP_RESET) begin
            emit = 1'b1; st_n = S_IDLE;
          end else if (op == OP_QUERY && hit.qry) begin
            emit = 1'b1; idx_n = C_QUERY; st_n = S_QUERY; qret_n = 1'b1;
          end
        end
        S_QUERY: begin
          if (op == OP_RESET) begin
            emit = 1'b1; st_n = qret_q ? S_IDENT : S_IDLE;
          end
        end
        S_BYP: begin
          if (op == OP_PROG)       st_n = S_BPDATA;
          else if (op == OP_IDENT) st_n = S_BEXIT;
          else if (op == OP_RESET) emit = 1'b1;
        end
        S_BPDATA: begin
          emit = 1'b1; idx_n = C_BPROG; st_n = S_BUSY; bret_n = 1'b1;
        end
        S_BEXIT: begin
          if (op == OP_BEXIT) begin
            emit = 1'b1; idx_n = C_BYP_OUT; st_n = S_IDLE;
          end else begin
            st_n = S_BYP;
          end
        end
        S_BUSY_BE: begin
          if (op == OP_SUSP) begin
            emit = 1'b1; idx_n = C_SUSP; st_n = S_IDLE; susp_n = 1'b1;
          end
        end
        default: ;
      endcase
    end
    // completion overrides any write in the same cycle
    if (pe_done) begin
      if (st_q == S_BUSY) begin
        st_n = bret_q ? S_BYP : S_IDLE;
      end else if (st_q == S_BUSY_BE) begin
        st_n = S_IDLE; susp_n = 1'b0; emit = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      susp_q <= 1'b0;
      qret_q <= 1'b0;
      bret_q <= 1'b0;
    end else if (sync_clr) begin
      st_q   <= S_IDLE;
      susp_q <= 1'b0;
      qret_q <= 1'b0;
      bret_q <= 1'b0;
    end else if (adv) begin
      st_q   <= st_n;
      susp_q <= susp_n;
      qret_q <= qret_n;
      bret_q <= bret_n;
    end
  end

  assign emit_idx    = idx_n;
  assign mode_ident  = (st_q == S_IDENT);
  assign mode_query  = (st_q == S_QUERY);
  assign mode_bypass = (st_q == S_BYP) || (st_q == S_BPDATA) || (st_q == S_BEXIT);
  assign busy        = (st_q == S_BUSY) || (st_q == S_BUSY_BE);
  assign erase_susp  = susp_q;

endmodule

// File: rtl/flash_cmd_out.sv
module flash_cmd_out
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_clr,
  input  logic              emit,
  input  logic [IDX_W-1:0]  emit_idx,
  input  logic [ADDR_W:0]   full_addr,
  input  logic [DATA_W-1:0] data,
  output logic              cmd_vld,
  output logic [CMD_N-1:0]  cmd_code,
  output logic [ADDR_W:0]   cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);

  logic [CMD_N-1:0] oh;

  for (genvar i = 0; i < CMD_N; i++) begin : g_oh
    assign oh[i] = (emit_idx == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_vld  <= 1'b0;
      cmd_code <= '0;
    end else if (sync_clr) begin
      cmd_vld  <= 1'b0;
      cmd_code <= '0;
    end else begin
      cmd_vld  <= emit;
      cmd_code <= emit ? oh : '0;
    end
  end

  // payload registers only load on a decoded command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_addr <= '0;
      cmd_data <= '0;
    end else if (emit) begin
      cmd_addr <= full_addr;
      cmd_data <= data;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_clr,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_lsb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              byte_mode,
  input  logic              pe_done,
  output logic              cmd_vld,
  output logic [CMD_N-1:0]  cmd_code,
  output logic [ADDR_W:0]   cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              mode_ident,
  output logic              mode_query,
  output logic              mode_bypass,
  output logic              busy,
  output logic              erase_susp
);

  key_hit_t         hit;
  logic             emit;
  logic [IDX_W-1:0] emit_idx;
  logic [ADDR_W:0]  full_addr;

  assign full_addr = {wr_addr, byte_mode & wr_lsb};

  flash_cmd_match u_match (
    .addr_lo   (wr_addr[10:0]),
    .lsb       (wr_lsb),
    .byte_mode (byte_mode),
    .hit       (hit)
  );

  flash_cmd_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_clr    (sync_clr),
    .wr_stb      (wr_stb),
    .hit         (hit),
    .op          (wr_data[7:0]),
    .pe_done     (pe_done),
    .emit        (emit),
    .emit_idx    (emit_idx),
    .mode_ident  (mode_ident),
    .mode_query  (mode_query),
    .mode_bypass (mode_bypass),
    .busy        (busy),
    .erase_susp  (erase_susp)
  );

  flash_cmd_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_clr  (sync_clr),
    .emit      (emit),
    .emit_idx  (emit_idx),
    .full_addr (full_addr),
    .data      (wr_data),
    .cmd_vld   (cmd_vld),
    .cmd_code  (cmd_code),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data)
  );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sync_clr,
  input logic        wr_stb,
  input logic [7:0]  op,
  input logic        cmd_vld,
  input logic [10:0] cmd_code,
  input logic        mode_ident,
  input logic        mode_query,
  input logic        mode_bypass,
  input logic        busy,
  input logic        erase_susp
);

  AST_CODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> $countones(cmd_code) == 1); // R13

  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> !cmd_vld); // R13

  AST_MODES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mode_ident, mode_query, mode_bypass, busy})); // R8

  AST_BUSY_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_stb && op != 8'hB0 && !sync_clr) |=> !cmd_vld); // R11

  AST_SUSP_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_code[6]) |-> $past(busy)); // R11

  AST_RESUME_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_code[7]) |-> ($past(erase_susp) && !$past(mode_ident)
                                  && !$past(mode_query) && !$past(mode_bypass))); // R12

  AST_BYP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bypass && wr_stb && op == 8'hF0 && !sync_clr) |=> (mode_bypass || busy)); // R9

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_clr    (sync_clr),
  .wr_stb      (wr_stb),
  .op          (wr_data[7:0]),
  .cmd_vld     (cmd_vld),
  .cmd_code    (cmd_code),
  .mode_ident  (mode_ident),
  .mode_query  (mode_query),
  .mode_bypass (mode_bypass),
  .busy        (busy),
  .erase_susp  (erase_susp)
);

// File: tb/flash_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;

  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n, sync_clr, wr_stb, wr_lsb, byte_mode, pe_done;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          cmd_vld;
  logic [10:0]   cmd_code;
  logic [AW:0]   cmd_addr;
  logic [DW-1:0] cmd_data;
  logic          mode_ident, mode_query, mode_bypass, busy, erase_susp;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  typedef struct {
    bit          vld;
    int          idx;
    logic [AW:0] addr;
    logic [DW-1:0] data;
    string       req;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  bit   seen  = 0;
  bit   fin   = 0;

  always @(posedge clk) seen <= wr_stb && rst_n;

  // monitor: result of a write is due one edge after it was sampled
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      if (seen && q.size() > 0) begin
        exp_t e;
        logic [10:0] ec;
        e  = q.pop_front();
        ec = e.vld ? (11'b1 << e.idx) : 11'b0;
        total++;
        if (cmd_vld !== e.vld || cmd_code !== ec) begin
          bad++;
          $display("FAIL %s: vld/code got %0b/%h expected %0b/%h", e.req, cmd_vld, cmd_code, e.vld, ec);
        end else if (e.vld && (e.idx == 2 || e.idx == 3) &&
                     (cmd_addr !== e.addr || cmd_data !== e.data)) begin
          bad++;
          $display("FAIL %s: addr/data got %h/%h expected %h/%h", e.req, cmd_addr, cmd_data, e.addr, e.data);
        end
      end else if (!seen && cmd_vld) begin
        total++; bad++;
        $display("FAIL R13: strobe without write got %0b expected 0", cmd_vld);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic l, input logic [DW-1:0] d,
                    input logic bm, input bit ev, input int ci, input string rq,
                    input logic [AW:0] ea = '0);
    exp_t e;
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_lsb = l; wr_data = d; byte_mode = bm;
    e.vld = ev; e.idx = ci; e.addr = ea; e.data = d; e.req = rq;
    q.push_back(e);
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic unlock(input logic bm, input string rq);
    wr(20'h00555, 1'b0, 16'h00AA, bm, 0, 0, rq);
    wr(20'h002AA, bm, 16'h0055, bm, 0, 0, rq);
  endtask

  task automatic modes(input logic i, input logic qy, input logic b, input logic bz,
                       input logic s, input string rq);
    total++;
    if ({mode_ident, mode_query, mode_bypass, busy, erase_susp} !== {i, qy, b, bz, s}) begin
      bad++;
      $display("FAIL %s: modes got %b expected %b", rq,
               {mode_ident, mode_query, mode_bypass, busy, erase_susp}, {i, qy, b, bz, s});
    end
  endtask

  task automatic done_pulse();
    @(negedge clk); pe_done = 1'b1;
    @(negedge clk); pe_done = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sync_clr = 0; wr_stb = 0; wr_lsb = 0; byte_mode = 0; pe_done = 0;
    wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    total++;
    if (cmd_vld !== 1'b0) begin bad++; $display("FAIL R1: cmd_vld got %b expected 0", cmd_vld); end
    modes(0, 0, 0, 0, 0, "R1");

    // R6 single-write reset
    wr(20'h12345, 0, 16'h00F0, 0, 1, 0, "R6 single reset");
    // R2 word-mode identifier entry, R8 masked write, R6/R7 query nesting
    unlock(0, "R2");
    wr(20'h00555, 0, 16'h0090, 0, 1, 1, "R2 ident x16");
    modes(1, 0, 0, 0, 0, "R2");
    wr(20'h00555, 0, 16'h00A0, 0, 0, 0, "R8 ident ignores");
    modes(1, 0, 0, 0, 0, "R8");
    wr(20'h00055, 0, 16'h0098, 0, 1, 8, "R6 query from ident");
    modes(0, 1, 0, 0, 0, "R6");
    wr(20'h00000, 0, 16'h00F0, 0, 1, 0, "R7 first reset");
    modes(1, 0, 0, 0, 0, "R7");
    wr(20'h00000, 0, 16'h00F0, 0, 1, 0, "R7 second reset");
    modes(0, 0, 0, 0, 0, "R7");

    // R2 byte-mode identifier entry
    unlock(1, "R2 x8");
    wr(20'h00555, 0, 16'h0090, 1, 1, 1, "R2 ident x8");
    modes(1, 0, 0, 0, 0, "R2 x8");
    wr(20'h00000, 0, 16'h00F0, 1, 1, 0, "R2 exit");
    // R6 byte-mode query from array, exit back to array
    wr(20'h00055, 0, 16'h0098, 1, 1, 8, "R6 query x8");
    wr(20'h00000, 0, 16'h00F0, 1, 1, 0, "R7 query to array");
    modes(0, 0, 0, 0, 0, "R7 array");

    // R5 byte-mode prefix with a word-mode second address breaks the sequence
    wr(20'h00555, 0, 16'h00AA, 1, 0, 0, "R5");
    wr(20'h002AA, 0, 16'h0055, 1, 0, 0, "R5 wrong lane");
    wr(20'h00555, 0, 16'h0090, 1, 0, 0, "R5 discarded");
    modes(0, 0, 0, 0, 0, "R5");

    // R4 upper address and data bits ignored
    wr(20'hFF555, 0, 16'hABAA, 0, 0, 0, "R4");
    wr(20'h802AA, 0, 16'h1255, 0, 0, 0, "R4");
    wr(20'h3D555, 0, 16'h7790, 0, 1, 1, "R4 ident");
    wr(20'h00000, 0, 16'h00F0, 0, 1, 0, "R4 exit");

    // R6 three-write reset
    unlock(0, "R6");
    wr(20'h00777, 0, 16'h00F0, 0, 1, 0, "R6 prefixed reset");

    // R3 program, R11 busy mutes writes
    unlock(0, "R3");
    wr(20'h00555, 0, 16'h00A0, 0, 0, 0, "R3");
    wr(20'h12345, 0, 16'hBEEF, 0, 1, 2, "R3 program", {20'h12345, 1'b0});
    modes(0, 0, 0, 1, 0, "R3 busy");
    wr(20'h00000, 0, 16'h00F0, 0, 0, 0, "R11 busy mute");
    done_pulse();
    modes(0, 0, 0, 0, 0, "R3 done");
    // R3 byte-mode program address carries the lane bit
    unlock(1, "R3 x8");
    wr(20'h00555, 0, 16'h00A0, 1, 0, 0, "R3 x8");
    wr(20'h00100, 1, 16'h0033, 1, 1, 2, "R3 program x8", {20'h00100, 1'b1});
    done_pulse();

    // R10 chip erase, R11 suspend refused
    unlock(0, "R10"); wr(20'h00555, 0, 16'h0080, 0, 0, 0, "R10");
    unlock(0, "R10"); wr(20'h00555, 0, 16'h0010, 0, 1, 4, "R10 chip");
    wr(20'h00000, 0, 16'h00B0, 0, 0, 0, "R11 chip no suspend");
    done_pulse();

    // R12 resume not accepted when not suspended
    wr(20'h00000, 0, 16'h0030, 0, 0, 0, "R12 no suspend");
    modes(0, 0, 0, 0, 0, "R12");

    // R10 block erase, R11 suspend
    unlock(0, "R10"); wr(20'h00555, 0, 16'h0080, 0, 0, 0, "R10");
    unlock(0, "R10"); wr(20'h40000, 0, 16'h0030, 0, 1, 5, "R10 block");
    wr(20'h50000, 0, 16'h0030, 0, 0, 0, "R11 extra block ignored");
    wr(20'h00000, 0, 16'h00B0, 0, 1, 6, "R11 suspend");
    modes(0, 0, 0, 0, 1, "R11 suspended");

    // R12 resume gated by mode
    unlock(0, "R12"); wr(20'h00555, 0, 16'h0090, 0, 1, 1, "R12 ident");
    wr(20'h00000, 0, 16'h0030, 0, 0, 0, "R12 ident blocks resume");
    wr(20'h00000, 0, 16'h00F0, 0, 1, 0, "R12 back");
    wr(20'h00000, 0, 16'h0030, 0, 1, 7, "R12 resume");
    modes(0, 0, 0, 1, 0, "R12 resumed");
    done_pulse();

    // R9 bypass mode
    unlock(0, "R9"); wr(20'h00555, 0, 16'h0020, 0, 1, 9, "R9 enter");
    modes(0, 0, 1, 0, 0, "R9");
    wr(20'h00000, 0, 16'h00A0, 0, 0, 0, "R9");
    wr(20'h00777, 0, 16'h5A5A, 0, 1, 3, "R9 bypass program", {20'h00777, 1'b0});
    done_pulse();
    modes(0, 0, 1, 0, 0, "R9 back");
    wr(20'h00000, 0, 16'h00F0, 0, 1, 0, "R9 reset stays");
    modes(0, 0, 1, 0, 0, "R9 stays");
    wr(20'h00000, 0, 16'h0090, 0, 0, 0, "R9");
    wr(20'h00000, 0, 16'h0000, 0, 1, 10, "R9 exit");
    modes(0, 0, 0, 0, 0, "R9 out");

    // R1 synchronous clear
    unlock(0, "R1"); wr(20'h00555, 0, 16'h0020, 0, 1, 9, "R1 setup");
    @(negedge clk); sync_clr = 1;
    @(negedge clk); sync_clr = 0;
    modes(0, 0, 0, 0, 0, "R1 clear");
    unlock(0, "R1");
    @(negedge clk); sync_clr = 1;
    @(negedge clk); sync_clr = 0;
    wr(20'h00555, 0, 16'h0090, 0, 0, 0, "R1 partial dropped");

    repeat (3) @(negedge clk);
    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule